// File: doc/BRIEF.md
# I2C Transfer Interrupt and Clock-Hold Unit

This block sits next to an I2C shift engine. It turns the engine's event strobes into a one-cycle transfer-complete interrupt pulse. It also keeps a pending flag that is active-low. While that flag is low, the block asks the pad logic to hold the serial clock line low, so the bus stalls until software has serviced the transfer. Software releases the bus in one of two ways: it writes the data register, or it writes a 1 to the flag bit of the control register.

Which strobes raise an interrupt depends on two settings: master or slave mode, and whether acknowledge generation is turned off. In master mode, the interrupt follows the acknowledge slot of a byte whose programmed bit count has been reached. In slave mode, it follows an own-address match, a general call, or the end of a data byte sent after the slave was selected. Releasing the hold has a floor. After the flag rises, the clock line is kept low for a programmable number of cycles, which preserves a full low period.

Top module: `i2c_irq_hold`

## Requirements
- R1: In master mode (`cfg_master`=1), `ev_ack_done` raises `irq_pulse` on the next cycle. This happens only if `ev_bits_done` was seen in the same cycle, or at any time since the last `ev_ack_done` or mode change.
- R2: In slave mode with `cfg_noack`=0, `ev_addr_match` raises `irq_pulse` on the next cycle.
- R3: In slave mode with `cfg_noack`=0, `ev_gcall` raises `irq_pulse` on the next cycle.
- R4: In slave mode, `ev_data_done` raises `irq_pulse` on the next cycle if `ev_addr_match` or `ev_gcall` occurred in an earlier cycle since the block last left master mode. This holds whatever the value of `cfg_noack`.
- R5: In slave mode with `cfg_noack`=1, `ev_addr_match` and `ev_gcall` raise no interrupt.
- R6: Every interrupt drives `pend_flag` to 0 at the same clock edge that raises the one-cycle `irq_pulse`.
- R7: While `pend_flag` is 0, `scl_hold` is 1.
- R8: A `wr_data` strobe sets `pend_flag` to 1 on the next cycle.
- R9: A `wr_ctrl` strobe sets `pend_flag` to 1 when `wr_ctrl_bit`=1. When `wr_ctrl_bit`=0 it has no effect, so the flag stays 0 and the hold stays on.
- R10: When `pend_flag` rises, `scl_hold` stays 1 for `cfg_low_cycles` further cycles, using the value sampled at that edge. A value of 0 releases the hold immediately. A new interrupt cancels the countdown.
- R11: After reset, `pend_flag`=1, `irq_pulse`=0 and `scl_hold`=0.
- R12: If an interrupt event and a flag-setting write arrive in the same cycle, the event wins and `pend_flag` goes to 0.
- R13: Master mode ignores the slave strobes. Slave mode ignores `ev_bits_done` and `ev_ack_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1 = master mode, 0 = slave mode |
| cfg_noack | input | 1 | 1 = acknowledge generation disabled |
| cfg_low_cycles | input | CNT_W | Minimum cycles the hold is kept after the flag rises |
| ev_bits_done | input | 1 | Strobe: programmed bit count reached |
| ev_ack_done | input | 1 | Strobe: acknowledge slot finished |
| ev_addr_match | input | 1 | Strobe: own address acknowledged |
| ev_gcall | input | 1 | Strobe: general call acknowledged |
| ev_data_done | input | 1 | Strobe: slave data byte finished |
| wr_data | input | 1 | Strobe: data register written |
| wr_ctrl | input | 1 | Strobe: control register written |
| wr_ctrl_bit | input | 1 | Value written to the flag bit of the control register |
| pend_flag | output | 1 | Pending flag, 0 = interrupt awaiting service |
| irq_pulse | output | 1 | One-cycle interrupt request |
| scl_hold | output | 1 | 1 = pull the serial clock line low |

## Verification
A strobe or write that is present before clock edge N has its results on `irq_pulse` and `pend_flag` one register later, right after edge N. `scl_hold` follows the flag in that same cycle, and its release comes `cfg_low_cycles` edges after the flag's rising edge. The bench drives inputs on falling edges. It advances its reference state at the rising edge and compares all three outputs at the next falling edge, so every check falls in exactly the cycle it is due. Seeded random strobes are combined with directed sequences for the write-0 case, simultaneous event and write, the suppressed acknowledge, and zero and non-zero release delays.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

   typedef enum logic [2:0] {
      CAUSE_NONE,
      CAUSE_MST_XFER,
      CAUSE_SLV_ADDR,
      CAUSE_SLV_GCALL,
      CAUSE_SLV_DATA
   } irq_cause_e;

   typedef struct packed {
      logic bits_done;
      logic ack_done;
      logic addr_match;
      logic gcall;
      logic data_done;
   } shift_ev_t;

endpackage

// File: rtl/irq_event_decode.sv
module irq_event_decode
   import i2c_irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       master,
   input  logic       noack,
   input  shift_ev_t  ev,
   output irq_cause_e cause,
   output logic       req
);

   logic armed_q;
   logic sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         sel_q   <= 1'b0;
      end else begin
         if (!master)
            armed_q <= 1'b0;
         else if (ev.ack_done)
            armed_q <= 1'b0;
         else if (ev.bits_done)
            armed_q <= 1'b1;

         if (master)
            sel_q <= 1'b0;
         else if (ev.addr_match || ev.gcall)
            sel_q <= 1'b1;
      end
   end

   always_comb begin
      cause = CAUSE_NONE;
      if (master) begin
         if (ev.ack_done && (armed_q || ev.bits_done))
            cause = CAUSE_MST_XFER;
      end else begin
         if (ev.data_done && sel_q)
            cause = CAUSE_SLV_DATA;
         else if (!noack && ev.addr_match)
            cause = CAUSE_SLV_ADDR;
         else if (!noack && ev.gcall)
            cause = CAUSE_SLV_GCALL;
      end
   end

   assign req = (cause != CAUSE_NONE);

   // R4: a selected slave keeps its selection until master mode is entered
   assert_sel_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q && !master) |=> sel_q);

endmodule

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic wr_data,
   input  logic wr_ctrl,
   input  logic wr_ctrl_bit,
   output logic flag_q,
   output logic irq_q,
   output logic rise
);

   logic set_req;

   assign set_req = wr_data || (wr_ctrl && wr_ctrl_bit);
   assign rise    = !flag_q && set_req && !req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b1;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= req;
         if (req)
            flag_q <= 1'b0;
         else if (set_req)
            flag_q <= 1'b1;
      end
   end

   assert_event_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> (!flag_q && irq_q));

   assert_write_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && !req) |=> flag_q);

   assert_zero_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !req && !wr_data && wr_ctrl && !wr_ctrl_bit) |=> !flag_q);

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             clear,
   input  logic [CNT_W-1:0] low_cycles,
   output logic             busy
);

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= ZERO;
      else if (clear)
         cnt_q <= ZERO;
      else if (load)
         cnt_q <= low_cycles;
      else if (cnt_q != ZERO)
         cnt_q <= cnt_q - ONE;
   end

   assign busy = (cnt_q != ZERO);

   assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clear) |=> (cnt_q == $past(low_cycles)));

   assert_countdown_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load && !clear) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/i2c_irq_hold.sv
module i2c_irq_hold
   import i2c_irq_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter bit HOLD_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_master,
   input  logic             cfg_noack,
   input  logic [CNT_W-1:0] cfg_low_cycles,
   input  logic             ev_bits_done,
   input  logic             ev_ack_done,
   input  logic             ev_addr_match,
   input  logic             ev_gcall,
   input  logic             ev_data_done,
   input  logic             wr_data,
   input  logic             wr_ctrl,
   input  logic             wr_ctrl_bit,
   output logic             pend_flag,
   output logic             irq_pulse,
   output logic             scl_hold
);

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
      $error("i2c_irq_hold: CNT_W must lie in 1..16");
   end

   shift_ev_t  ev;
   irq_cause_e cause;
   logic       req;
   logic       rise;
   logic       busy;
   logic       hold_comb;

   assign ev = '{bits_done:  ev_bits_done,
                 ack_done:   ev_ack_done,
                 addr_match: ev_addr_match,
                 gcall:      ev_gcall,
                 data_done:  ev_data_done};

   irq_event_decode u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .master (cfg_master),
      .noack  (cfg_noack),
      .ev     (ev),
      .cause  (cause),
      .req    (req)
   );

   irq_flag_ctl u_flag (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (req),
      .wr_data     (wr_data),
      .wr_ctrl     (wr_ctrl),
      .wr_ctrl_bit (wr_ctrl_bit),
      .flag_q      (pend_flag),
      .irq_q       (irq_pulse),
      .rise        (rise)
   );

   hold_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (rise),
      .clear      (req),
      .low_cycles (cfg_low_cycles),
      .busy       (busy)
   );

   assign hold_comb = !pend_flag || busy;

   if (HOLD_REG) begin : g_hold_reg
      logic hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hold_q <= 1'b0;
         else        hold_q <= hold_comb;
      end
      assign scl_hold = hold_q;
   end else begin : g_hold_comb
      assign scl_hold = hold_comb;

      assert_hold_while_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !pend_flag |-> scl_hold);
   end

   assert_irq_clears_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> !pend_flag);

   assert_noack_suppress_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_master && cfg_noack && !ev_data_done) |=> !irq_pulse);

   assert_master_ignores_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && !ev_ack_done) |=> !irq_pulse);

endmodule

// File: tb/sim_i2c_irq_hold.sv
module sim_i2c_irq_hold;

   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_master = 1'b1;
   logic             cfg_noack = 1'b0;
   logic [CNT_W-1:0] cfg_low_cycles = '0;
   logic             ev_bits_done = 1'b0, ev_ack_done = 1'b0, ev_addr_match = 1'b0;
   logic             ev_gcall = 1'b0, ev_data_done = 1'b0;
   logic             wr_data = 1'b0, wr_ctrl = 1'b0, wr_ctrl_bit = 1'b0;
   logic             pend_flag, irq_pulse, scl_hold;

   int               n_tests = 0;
   int               n_fail = 0;
   bit               done = 1'b0;

   // reference state
   bit               m_flag = 1'b1, m_irq = 1'b0, m_armed = 1'b0, m_sel = 1'b0;
   int               m_cnt = 0;
   string            irq_tag = "R11", flag_tag = "R11";

   always #2 clk = ~clk;

   i2c_irq_hold #(.CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_noack(cfg_noack),
      .cfg_low_cycles(cfg_low_cycles), .ev_bits_done(ev_bits_done),
      .ev_ack_done(ev_ack_done), .ev_addr_match(ev_addr_match), .ev_gcall(ev_gcall),
      .ev_data_done(ev_data_done), .wr_data(wr_data), .wr_ctrl(wr_ctrl),
      .wr_ctrl_bit(wr_ctrl_bit), .pend_flag(pend_flag), .irq_pulse(irq_pulse),
      .scl_hold(scl_hold)
   );

   task automatic chk(input bit act, input bit exp, input string tag, input string what);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic bit exp_hold();
      return !m_flag || (m_cnt != 0);
   endfunction

   // reference model from the requirements, advanced once per rising edge
   task automatic model_step();
      bit ev, set;
      ev = 1'b0;
      irq_tag = "R6";
      if (cfg_master) begin
         if (ev_ack_done && (m_armed || ev_bits_done)) begin ev = 1; irq_tag = "R1"; end
         else if (ev_addr_match || ev_gcall || ev_data_done) irq_tag = "R13";
      end else begin
         if (ev_data_done && m_sel) begin ev = 1; irq_tag = "R4"; end
         else if (!cfg_noack && ev_addr_match) begin ev = 1; irq_tag = "R2"; end
         else if (!cfg_noack && ev_gcall) begin ev = 1; irq_tag = "R3"; end
         else if (cfg_noack && (ev_addr_match || ev_gcall)) irq_tag = "R5";
         else if (ev_ack_done || ev_bits_done) irq_tag = "R13";
      end
      set = wr_data || (wr_ctrl && wr_ctrl_bit);
      if (ev && set) flag_tag = "R12";
      else if (ev) flag_tag = "R6";
      else if (wr_ctrl && !wr_ctrl_bit && !wr_data) flag_tag = "R9";
      else flag_tag = "R8";

      if (ev) m_cnt = 0;
      else if (!m_flag && set) m_cnt = int'(cfg_low_cycles);
      else if (m_cnt != 0) m_cnt--;

      m_armed = cfg_master ? (ev_ack_done ? 1'b0 : (m_armed || ev_bits_done)) : 1'b0;
      m_sel   = cfg_master ? 1'b0 : (m_sel || ev_addr_match || ev_gcall);
      m_irq   = ev;
      if (ev) m_flag = 1'b0;
      else if (set) m_flag = 1'b1;
   endtask

   task automatic clear_strobes();
      ev_bits_done = 0; ev_ack_done = 0; ev_addr_match = 0; ev_gcall = 0;
      ev_data_done = 0; wr_data = 0; wr_ctrl = 0; wr_ctrl_bit = 0;
   endtask

   // inputs were driven at a falling edge; advance one cycle and compare
   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(irq_pulse, m_irq, irq_tag, "irq_pulse");
      chk(pend_flag, m_flag, flag_tag, "pend_flag");
      chk(scl_hold, exp_hold(), m_flag ? "R10" : "R7", "scl_hold");
      clear_strobes();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(pend_flag, 1'b1, "R11", "pend_flag after reset");
      chk(irq_pulse, 1'b0, "R11", "irq_pulse after reset");
      chk(scl_hold, 1'b0, "R11", "scl_hold after reset");
      rst_n = 1'b1;
      @(negedge clk);

      // R1: bits then ack in master mode, release with zero delay (R10)
      cfg_master = 1; cfg_low_cycles = 0;
      ev_bits_done = 1; tick();
      ev_ack_done = 1; tick();
      chk(irq_pulse, 1'b1, "R1", "directed master irq");
      tick();
      // R9: writing 0 leaves the hold on
      wr_ctrl = 1; wr_ctrl_bit = 0; tick();
      chk(scl_hold, 1'b1, "R9", "hold after write of 0");
      wr_ctrl = 1; wr_ctrl_bit = 1; tick();
      chk(scl_hold, 1'b0, "R10", "zero-delay release");

      // R2 and R10 with a delay of 5
      cfg_master = 0; cfg_noack = 0; cfg_low_cycles = 5; tick();
      ev_addr_match = 1; tick();
      chk(pend_flag, 1'b0, "R2", "flag after address match");
      wr_data = 1; tick();
      for (int i = 0; i < 5; i++) begin
         chk(scl_hold, 1'b1, "R10", "hold during low period");
         tick();
      end
      chk(scl_hold, 1'b0, "R10", "released after low period");

      // R5 then R4 with acknowledge disabled
      cfg_noack = 1; ev_gcall = 1; tick();
      chk(irq_pulse, 1'b0, "R5", "gcall suppressed");
      ev_data_done = 1; tick();
      chk(irq_pulse, 1'b1, "R4", "data done with noack");
      // R12: event with a write in the same cycle
      ev_data_done = 1; wr_data = 1; tick();
      chk(pend_flag, 1'b0, "R12", "event beats write");
      wr_data = 1; tick();

      // random phase
      for (int c = 0; c < 4000; c++) begin
         if ($urandom % 150 == 0) cfg_master = ~cfg_master;
         if ($urandom % 100 == 0) cfg_noack = ~cfg_noack;
         if ($urandom % 80 == 0) cfg_low_cycles = CNT_W'($urandom % 8);
         ev_bits_done  = ($urandom % 6 == 0);
         ev_ack_done   = ($urandom % 5 == 0);
         ev_addr_match = ($urandom % 12 == 0);
         ev_gcall      = ($urandom % 16 == 0);
         ev_data_done  = ($urandom % 8 == 0);
         wr_data       = ($urandom % 10 == 0);
         wr_ctrl       = ($urandom % 10 == 0);
         wr_ctrl_bit   = $urandom % 2;
         tick();
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule